// File: doc/BRIEF.md
# Password-Guarded Control Register Bank with Reset Sequencer

This block holds a small bank of 8-bit control settings, reached through 16-bit bus words: three flash-controller control registers and one watchdog control register. Every write to the bank must carry a fixed password in the upper byte of the word. A write with a correct password stores its low byte. A write with any other upper byte is refused, leaves the register as it was, and counts as a key violation.

A reset sequencer drives the system-wide clear output. A power-on reset, brownouts included, gives a short clear pulse, after which the system runs. A key violation raises the clear output and keeps it raised until a dedicated clear input is pulsed. Flash data-write strobes are also watched. A strobe that arrives while the program-enable bit is off is flagged as an access violation, but the system is not reset for it. Sticky status flags record what happened.

Top module: `keyguard_top`

## Requirements
- R1: A write with `wr_en` high to address 0..3 (0 = flash control A, whose bit 0 is program enable; 1 = flash control B; 2 = flash control C; 3 = watchdog control) while `puc` is low and with `wr_data[15:8]` equal to 0xA5 stores `wr_data[7:0]`. The new value is visible on the read port after that clock edge.
- R2: The read port is combinational. A read of address 0..3 returns 0x96 in bits [15:8] and the stored byte in bits [7:0]. A read of address 4 returns the status word: bit 0 is the power-on flag, bit 1 the key-violation flag, bit 2 the access-violation flag, and all other bits are 0. Any other address reads 0.
- R3: A write to address 0..3 whose upper byte is not 0xA5 leaves the target register unchanged and sets the key-violation flag at that edge. This holds equally for the watchdog register.
- R4: While `por` is high, and for exactly 4 cycles after it falls, `puc` is high. It then goes low. The por reset clears all four registers to 0, sets the power-on flag, and clears the other two flags.
- R5: After a key violation, `puc` is high from the next cycle on and stays high until `viol_clear` is sampled high.
- R6: `viol_clear` sampled high clears all three flags at that edge. If the system is held, it also releases the hold, so `puc` is low in the next cycle. Register contents are kept.
- R7: The flags are sticky. Only `viol_clear` or `por` clears them. A violation in the same cycle as `viol_clear` leaves its flag set.
- R8: A `fl_wr` strobe while `puc` is low and register 0 bit 0 is 0 sets the access-violation flag. With that bit set to 1, the strobe sets no flag. An access violation never raises `puc`.
- R9: While `puc` is high, bus writes and `fl_wr` strobes have no effect: no register changes and no flag is set.
- R10: Writes to addresses 4..7 are ignored. They change no register and raise no violation, whatever their upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on / brownout reset, synchronous, active high |
| viol_clear | input | 1 | Clears the status flags and releases a violation hold |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 3 | Bus write address |
| wr_data | input | 16 | Bus write word: password in [15:8], value in [7:0] |
| rd_addr | input | 3 | Bus read address |
| rd_data | output | 16 | Bus read word |
| fl_wr | input | 1 | Flash data-write strobe |
| puc | output | 1 | System clear, active high |
| stat_por | output | 1 | Sticky power-on flag |
| stat_keyv | output | 1 | Sticky key-violation flag |
| stat_accv | output | 1 | Sticky access-violation flag |

## Verification
The assertions check on every cycle the properties that are purely local in time. These are: the exact width of the clear pulse after power-on, that a bad-password write always ends in a hold with a set flag and an unchanged bank, that a hold persists until cleared, and that the flags stay sticky. The same holds for access violations on strobes without program enable and for the absence of effect while `puc` is high. Only the bench scenarios can show the overall register map as seen from the bus. That covers the read tag and status layout, that unmapped writes are harmless, and that values written before a violation survive both the hold and its release. They also show that a clear and a violation in the same cycle leave the flag set.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam logic [BYTE_W-1:0] WRITE_KEY = 8'hA5;
    localparam logic [BYTE_W-1:0] READ_TAG  = 8'h96;

    typedef enum logic [1:0] {
        SEQ_PULSE = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

    // packed: acc_viol is bit 2, key_viol bit 1, por_seen bit 0
    typedef struct packed {
        logic acc_viol;
        logic key_viol;
        logic por_seen;
    } status_t;

    typedef struct packed {
        logic              key_viol;
        logic              acc_viol;
    } viol_t;

    function automatic logic key_matches(input logic [BYTE_W-1:0] upper);
        return upper == WRITE_KEY;
    endfunction

    function automatic logic [WORD_W-1:0] tag_word(input logic [BYTE_W-1:0] val);
        return {READ_TAG, val};
    endfunction

endpackage

// File: rtl/keyguard_keycheck.sv
module keyguard_keycheck
    import keyguard_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 3
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                fl_wr,
    input  logic                prog_en,
    input  logic                run,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [BYTE_W-1:0]   wr_byte,
    output viol_t               viol
);

    logic in_bank;
    logic key_good;

    assign in_bank  = ({1'b0, wr_addr} < (ADDR_W + 1)'(NUM_REGS));
    assign key_good = key_matches(wr_data[WORD_W-1:BYTE_W]);
    assign wr_byte  = wr_data[BYTE_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel[g] = wr_en && run && key_good && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        viol.key_viol = wr_en && run && in_bank && !key_good;
        viol.acc_viol = fl_wr && run && !prog_en;
    end

endmodule

// File: rtl/keyguard_regfile.sv
module keyguard_regfile
    import keyguard_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int ADDR_W      = 3,
    parameter int PROG_EN_BIT = 0
) (
    input  logic                           clk,
    input  logic                           por,
    input  logic [NUM_REGS-1:0]            wr_sel,
    input  logic [BYTE_W-1:0]              wr_byte,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  status_t                        status,
    output logic [WORD_W-1:0]              rd_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] reg_q,
    output logic                           prog_en
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (por) begin
                reg_q[g] <= '0;
            end else if (wr_sel[g]) begin
                reg_q[g] <= wr_byte;
            end
        end
    end

    assign prog_en = reg_q[0][PROG_EN_BIT];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = tag_word(reg_q[i]);
            end
        end
        if (rd_addr == STATUS_ADDR) begin
            rd_data = {{(WORD_W - $bits(status_t)){1'b0}}, status};
        end
    end

endmodule

// File: rtl/keyguard_sequencer.sv
module keyguard_sequencer
    import keyguard_pkg::*;
#(
    parameter int PUC_CYCLES = 4
) (
    input  logic    clk,
    input  logic    por,
    input  logic    viol_clear,
    input  viol_t   viol,
    output logic    run,
    output logic    puc,
    output status_t status
);

    localparam int CNT_W = (PUC_CYCLES > 1) ? $clog2(PUC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PUC_CYCLES - 1);

    seq_state_e state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= SEQ_PULSE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_PULSE: begin
                    if (cnt_q == LAST) begin
                        state_q <= SEQ_RUN;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                SEQ_RUN: begin
                    if (viol.key_viol) begin
                        state_q <= SEQ_HOLD;
                    end
                end
                SEQ_HOLD: begin
                    if (viol_clear) begin
                        state_q <= SEQ_RUN;
                    end
                end
                default: state_q <= SEQ_PULSE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            status.por_seen <= 1'b1;
            status.key_viol <= 1'b0;
            status.acc_viol <= 1'b0;
        end else begin
            if (viol_clear) begin
                status.por_seen <= 1'b0;
            end
            if (viol.key_viol) begin
                status.key_viol <= 1'b1;
            end else if (viol_clear) begin
                status.key_viol <= 1'b0;
            end
            if (viol.acc_viol) begin
                status.acc_viol <= 1'b1;
            end else if (viol_clear) begin
                status.acc_viol <= 1'b0;
            end
        end
    end

    assign run = (state_q == SEQ_RUN);
    assign puc = !run;

endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
    import keyguard_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int ADDR_W      = 3,
    parameter int PUC_CYCLES  = 4,
    parameter int PROG_EN_BIT = 0
) (
    input  logic              clk,
    input  logic              por,
    input  logic              viol_clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    input  logic              fl_wr,
    output logic              puc,
    output logic              stat_por,
    output logic              stat_keyv,
    output logic              stat_accv
);

    logic [NUM_REGS-1:0]             wr_sel;
    logic [BYTE_W-1:0]               wr_byte;
    logic [NUM_REGS-1:0][BYTE_W-1:0] reg_q;
    logic                            prog_en;
    logic                            run;
    viol_t                           viol;
    status_t                         status;

    keyguard_keycheck #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) i_keycheck (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fl_wr   (fl_wr),
        .prog_en (prog_en),
        .run     (run),
        .wr_sel  (wr_sel),
        .wr_byte (wr_byte),
        .viol    (viol)
    );

    keyguard_regfile #(
        .NUM_REGS    (NUM_REGS),
        .ADDR_W      (ADDR_W),
        .PROG_EN_BIT (PROG_EN_BIT)
    ) i_regfile (
        .clk     (clk),
        .por     (por),
        .wr_sel  (wr_sel),
        .wr_byte (wr_byte),
        .rd_addr (rd_addr),
        .status  (status),
        .rd_data (rd_data),
        .reg_q   (reg_q),
        .prog_en (prog_en)
    );

    keyguard_sequencer #(
        .PUC_CYCLES (PUC_CYCLES)
    ) i_sequencer (
        .clk        (clk),
        .por        (por),
        .viol_clear (viol_clear),
        .viol       (viol),
        .run        (run),
        .puc        (puc),
        .status     (status)
    );

    assign stat_por  = status.por_seen;
    assign stat_keyv = status.key_viol;
    assign stat_accv = status.acc_viol;

endmodule

// File: rtl/keyguard_checker.sv
module keyguard_checker #(
    parameter int NUM_REGS    = 4,
    parameter int ADDR_W      = 3,
    parameter int PUC_CYCLES  = 4,
    parameter int PROG_EN_BIT = 0
) (
    input logic                        clk,
    input logic                        por,
    input logic                        viol_clear,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [15:0]                 wr_data,
    input logic                        fl_wr,
    input logic                        puc,
    input logic                        stat_keyv,
    input logic                        stat_accv,
    input logic [NUM_REGS-1:0][7:0]    reg_q
);

    localparam int CW = $clog2(PUC_CYCLES + 2);

    logic [CW-1:0] since_por;
    logic          bad_wr;

    always_ff @(posedge clk) begin
        if (por) begin
            since_por <= '0;
        end else if (since_por != CW'(PUC_CYCLES + 1)) begin
            since_por <= since_por + 1'b1;
        end
    end

    assign bad_wr = wr_en && ({1'b0, wr_addr} < (ADDR_W + 1)'(NUM_REGS))
                    && (wr_data[15:8] != 8'hA5);

    AST_PUC_PULSE_HIGH: assert property (@(posedge clk) disable iff (por)
        (since_por < CW'(PUC_CYCLES)) |-> puc);                          // R4
    AST_PUC_PULSE_ENDS: assert property (@(posedge clk) disable iff (por)
        (since_por == CW'(PUC_CYCLES)) |-> !puc);                        // R4
    AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (por)
        (!puc && bad_wr) |=> (puc && stat_keyv));                        // R5
    AST_BAD_KEY_KEEPS_BANK: assert property (@(posedge clk) disable iff (por)
        (!puc && bad_wr) |=> $stable(reg_q));                            // R3
    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (por)
        (puc && stat_keyv && !viol_clear) |=> puc);                      // R5
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (por)
        (puc && stat_keyv && viol_clear) |=> (!puc && !stat_keyv));      // R6
    AST_KEYV_STICKY: assert property (@(posedge clk) disable iff (por)
        (stat_keyv && !viol_clear) |=> stat_keyv);                       // R7
    AST_ACCV_STICKY: assert property (@(posedge clk) disable iff (por)
        (stat_accv && !viol_clear) |=> stat_accv);                       // R7
    AST_ACC_VIOL_FLAG: assert property (@(posedge clk) disable iff (por)
        (!puc && fl_wr && !reg_q[0][PROG_EN_BIT]) |=> stat_accv);        // R8
    AST_ACC_NO_RESET: assert property (@(posedge clk) disable iff (por)
        (!puc && !wr_en && fl_wr) |=> !puc);                             // R8
    AST_HELD_NO_EFFECT: assert property (@(posedge clk) disable iff (por)
        (puc && !viol_clear) |=> ($stable(reg_q) && !$rose(stat_accv)
                                  && !$rose(stat_keyv)));                // R9

endmodule

bind keyguard_top keyguard_checker #(
    .NUM_REGS    (NUM_REGS),
    .ADDR_W      (ADDR_W),
    .PUC_CYCLES  (PUC_CYCLES),
    .PROG_EN_BIT (PROG_EN_BIT)
) i_keyguard_checker (
    .clk        (clk),
    .por        (por),
    .viol_clear (viol_clear),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .fl_wr      (fl_wr),
    .puc        (puc),
    .stat_keyv  (stat_keyv),
    .stat_accv  (stat_accv),
    .reg_q      (reg_q)
);

// File: tb/test_keyguard_top.sv
module test_keyguard_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        viol_clear = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        fl_wr = 1'b0;
    logic        puc;
    logic        stat_por;
    logic        stat_keyv;
    logic        stat_accv;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyguard_top i_keyguard_top (
        .clk        (clk),
        .por        (por),
        .viol_clear (viol_clear),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .fl_wr      (fl_wr),
        .puc        (puc),
        .stat_por   (stat_por),
        .stat_keyv  (stat_keyv),
        .stat_accv  (stat_accv)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_flash;
        @(negedge clk);
        fl_wr = 1'b1;
        @(negedge clk);
        fl_wr = 1'b0;
    endtask

    task automatic pulse_clear;
        @(negedge clk);
        viol_clear = 1'b1;
        @(negedge clk);
        viol_clear = 1'b0;
    endtask

    task automatic t_por;
        @(negedge clk);
        por = 1'b1;
        @(negedge clk);
        @(negedge clk);
        por = 1'b0;
        #1 check("R4 puc while pulse", {15'd0, puc}, 16'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1 check("R4 puc while pulse", {15'd0, puc}, 16'd1);
        end
        @(negedge clk);
        #1 check("R4 puc released", {15'd0, puc}, 16'd0);
        for (int i = 0; i < 4; i++) read_chk("R4 register cleared", 3'(i), 16'h9600);
        read_chk("R4 status after por", 3'd4, 16'h0001);
    endtask

    task automatic t_good_writes;
        bus_write(3'd3, 16'hA53C);
        read_chk("R1 watchdog write", 3'd3, 16'h963C);
        bus_write(3'd1, 16'hA57E);
        read_chk("R1 flash B write", 3'd1, 16'h967E);
        read_chk("R2 tag on untouched reg", 3'd2, 16'h9600);
        read_chk("R2 unmapped read", 3'd6, 16'h0000);
        read_chk("R1 no flag on good key", 3'd4, 16'h0001);
    endtask

    task automatic t_unmapped;
        bus_write(3'd4, 16'h1234);
        bus_write(3'd7, 16'hA5FF);
        read_chk("R10 status untouched", 3'd4, 16'h0001);
        check("R10 no hold", {15'd0, puc}, 16'd0);
        read_chk("R10 bank untouched", 3'd3, 16'h963C);
    endtask

    task automatic t_access;
        pulse_flash();
        read_chk("R8 access flag set", 3'd4, 16'h0005);
        check("R8 no hold on access", {15'd0, puc}, 16'd0);
        pulse_clear();
        read_chk("R6 clear flags", 3'd4, 16'h0000);
        bus_write(3'd0, 16'hA501);
        pulse_flash();
        read_chk("R8 enabled strobe ok", 3'd4, 16'h0000);
    endtask

    task automatic t_sticky;
        bus_write(3'd0, 16'hA500);
        pulse_flash();
        repeat (5) @(negedge clk);
        read_chk("R7 flag stays", 3'd4, 16'h0004);
        @(negedge clk);
        viol_clear = 1'b1; fl_wr = 1'b1;
        @(negedge clk);
        viol_clear = 1'b0; fl_wr = 1'b0;
        read_chk("R7 set beats clear", 3'd4, 16'h0004);
        pulse_clear();
        read_chk("R7 clear alone", 3'd4, 16'h0000);
    endtask

    task automatic t_key_violation;
        bus_write(3'd3, 16'h5AFF);
        check("R5 hold after bad key", {15'd0, puc}, 16'd1);
        read_chk("R3 key flag", 3'd4, 16'h0002);
        read_chk("R3 watchdog unchanged", 3'd3, 16'h963C);
        repeat (10) @(negedge clk);
        check("R5 hold persists", {15'd0, puc}, 16'd1);
        bus_write(3'd1, 16'hA500);
        read_chk("R9 write ignored in hold", 3'd1, 16'h967E);
        pulse_flash();
        read_chk("R9 strobe ignored in hold", 3'd4, 16'h0002);
        pulse_clear();
        check("R6 hold released", {15'd0, puc}, 16'd0);
        read_chk("R6 flags cleared", 3'd4, 16'h0000);
        read_chk("R6 bank kept", 3'd3, 16'h963C);
        bus_write(3'd0, 16'hA45A);
        check("R3 near-miss key holds", {15'd0, puc}, 16'd1);
        read_chk("R3 flash A unchanged", 3'd0, 16'h9600);
        pulse_clear();
    endtask

    task automatic t_por_again;
        t_por();
        read_chk("R4 bank cleared again", 3'd1, 16'h9600);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_por();
        t_good_writes();
        t_unmapped();
        t_access();
        t_sticky();
        t_key_violation();
        t_por_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule